// File: doc/BRIEF.md
# Cross-Clock Bypass Mailbox

This block moves one data word at a time from a sending port to a receiving port. The two ports run on unrelated clocks, and the word does not pass through any queue memory on the way. The sending port first selects bypass mode. It then writes a word, and the word is held in a message register. The receiving port then finds the word in its output register. A one-deep handshake controls the transfer. The sender sees an active-low "message pending" flag. The receiver sees an active-high "message available" flag.

The receiver also gets an active-low flag that tells it the sender has switched the path into bypass mode. Every flag is registered in the domain of the port that reads it. The handoff uses a request toggle and an acknowledge toggle. Each toggle crosses to the other clock through a two-flop synchronizer. The message register does not change while a message is pending. This lets the receiving side capture the word without a data synchronizer.

Top module: `xclk_bypass_mailbox`

## Requirements
- R1: While reset is asserted (rstN low) and after it is released, sendFullN is 1, recvAvail is 0, recvBypassN is 1 and recvData is 0.
- R2: recvBypassN follows the inverse of the bypassOn level, delayed by one send-clock register and a two-stage synchronizer in the receive clock. After a change of bypassOn it has settled within 4 receive-clock cycles.
- R3: A write is accepted when sendWrite is 1 at a send-clock edge while bypass mode is on and sendFullN is 1. After that edge sendFullN is 0.
- R4: recvAvail rises no earlier than the third receive-clock edge after the accepting send edge. When it is 1, recvData holds the accepted word.
- R5: A read (recvRead is 1 at a receive edge while recvAvail is 1) makes recvAvail 0 after that same edge.
- R6: After a read, sendFullN returns to 1 within 3 send-clock cycles of the acknowledge reaching the send side. A new write is then accepted.
- R7: A write attempted while sendFullN is 0 is ignored. The held word is not overwritten, and no second message is delivered.
- R8: A write while bypass mode is off is ignored. sendFullN stays 1 and recvAvail stays 0.
- R9: A read while recvAvail is 0 has no effect. recvAvail stays 0, recvData is unchanged, and the next message is still delivered normally.
- R10: recvData keeps the last delivered word after it has been read, until a new message arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sendClk | input | 1 | Sending-port clock |
| recvClk | input | 1 | Receiving-port clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| bypassOn | input | 1 | Sending port selects bypass mode (level) |
| sendWrite | input | 1 | Write strobe of the sending port |
| sendData | input | DW | Word to deliver |
| sendFullN | output | 1 | Low while a delivered word is unread |
| recvRead | input | 1 | Read strobe of the receiving port |
| recvData | output | DW | Receive-side output register |
| recvAvail | output | 1 | High while a word waits to be read |
| recvBypassN | output | 1 | Low while bypass mode is on |

## Verification
sendFullN is a send-domain result. It drops one send edge after the write, so the bench samples it at the send-clock falling edge that follows the write.

The other results are due after synchronizer delays. recvAvail and recvData come three receive edges after the write. sendFullN returns two to three send edges after the read. recvBypassN settles within four receive edges of a mode change.

Because the two clocks have no fixed phase relation, each delayed result is checked in two steps. First the bench confirms the result is still absent at a point where it cannot be due yet. It then polls at falling edges within a bounded window and fails the check if the window runs out.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadMsg;  // send domain: capture sendData into held register
    logic loadOut;  // receive domain: copy held register to output register
  } mbxStrobe_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= '0;
          else       chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       sendClk,
  input  logic       recvClk,
  input  logic       rstN,
  input  logic       bypassOn,
  input  logic       sendWrite,
  input  logic       recvRead,
  output mbxStrobe_t strobes,
  output logic       sendFullN,
  output logic       recvAvail,
  output logic       recvBypassN
);
  // ---------------- send domain ----------------
  logic modeQ;
  logic reqToggle;
  logic ackSynced;
  logic ackToggle;
  logic sendIdle;
  logic accept;

  mbx_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) ackSync (
    .clk(sendClk), .rstN(rstN), .d(ackToggle), .q(ackSynced)
  );

  assign sendIdle = (reqToggle == ackSynced);
  assign accept   = sendWrite && modeQ && sendIdle;

  always_ff @(posedge sendClk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= 1'b0;
      reqToggle <= 1'b0;
    end else begin
      modeQ <= bypassOn;
      if (accept) reqToggle <= ~reqToggle;
    end
  end

  assign sendFullN = sendIdle;

  // ---------------- receive domain ----------------
  logic reqSynced;
  logic seenToggle;
  logic modeSynced;
  logic newMsg;
  logic takeMsg;

  mbx_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) reqSync (
    .clk(recvClk), .rstN(rstN), .d(reqToggle), .q(reqSynced)
  );

  mbx_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) modeSync (
    .clk(recvClk), .rstN(rstN), .d(modeQ), .q(modeSynced)
  );

  assign newMsg    = (reqSynced != seenToggle);
  assign recvAvail = (seenToggle != ackToggle);
  assign takeMsg   = recvRead && recvAvail;

  always_ff @(posedge recvClk or negedge rstN) begin
    if (!rstN) begin
      seenToggle <= 1'b0;
      ackToggle  <= 1'b0;
    end else begin
      if (newMsg)  seenToggle <= reqSynced;
      if (takeMsg) ackToggle  <= seenToggle;
    end
  end

  assign recvBypassN     = ~modeSynced;
  assign strobes.loadMsg = accept;
  assign strobes.loadOut = newMsg;

  // R3
  full_drop_chk: assert property (@(posedge sendClk) disable iff (!rstN)
    strobes.loadMsg |=> !sendFullN);

  // R5
  avail_clear_chk: assert property (@(posedge recvClk) disable iff (!rstN)
    (recvAvail && recvRead) |=> !recvAvail);

  // R4
  out_avail_chk: assert property (@(posedge recvClk) disable iff (!rstN)
    strobes.loadOut |=> recvAvail);
endmodule

// File: rtl/mbx_data.sv
module mbx_data
  import mbx_pkg::*;
#(
  parameter int DW = 18
) (
  input  logic          sendClk,
  input  logic          recvClk,
  input  logic          rstN,
  input  mbxStrobe_t    strobes,
  input  logic [DW-1:0] sendData,
  output logic [DW-1:0] heldMsg,
  output logic [DW-1:0] recvData
);
  always_ff @(posedge sendClk or negedge rstN) begin
    if (!rstN)                heldMsg <= '0;
    else if (strobes.loadMsg) heldMsg <= sendData;
  end

  // heldMsg is stable while a request toggle is in flight
  always_ff @(posedge recvClk or negedge rstN) begin
    if (!rstN)                recvData <= '0;
    else if (strobes.loadOut) recvData <= heldMsg;
  end
endmodule

// File: rtl/xclk_bypass_mailbox.sv
module xclk_bypass_mailbox
  import mbx_pkg::*;
#(
  parameter int DW          = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic          sendClk,
  input  logic          recvClk,
  input  logic          rstN,
  input  logic          bypassOn,
  input  logic          sendWrite,
  input  logic [DW-1:0] sendData,
  output logic          sendFullN,
  input  logic          recvRead,
  output logic [DW-1:0] recvData,
  output logic          recvAvail,
  output logic          recvBypassN
);
  mbxStrobe_t    strobes;
  logic [DW-1:0] heldMsg;

  mbx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl (
    .sendClk(sendClk), .recvClk(recvClk), .rstN(rstN),
    .bypassOn(bypassOn), .sendWrite(sendWrite), .recvRead(recvRead),
    .strobes(strobes), .sendFullN(sendFullN),
    .recvAvail(recvAvail), .recvBypassN(recvBypassN)
  );

  mbx_data #(.DW(DW)) data (
    .sendClk(sendClk), .recvClk(recvClk), .rstN(rstN),
    .strobes(strobes), .sendData(sendData),
    .heldMsg(heldMsg), .recvData(recvData)
  );

  // R7
  held_msg_chk: assert property (@(posedge sendClk) disable iff (!rstN)
    !sendFullN |=> $stable(heldMsg));

  // R10
  out_hold_chk: assert property (@(posedge recvClk) disable iff (!rstN)
    recvAvail |=> $stable(recvData));
endmodule

// File: tb/xclk_bypass_mailbox_test.sv
module xclk_bypass_mailbox_test;
  localparam int CLK_PERIOD  = 10;
  localparam int RECV_PERIOD = 14;
  localparam int DW          = 18;
  localparam int NVEC        = 8;

  // {mode, data[17:0], expectAccept}
  localparam logic [DW+1:0] VEC [NVEC] = '{
    {1'b1, 18'h2A5A5, 1'b1},
    {1'b1, 18'h3FFFF, 1'b1},
    {1'b1, 18'h00000, 1'b1},
    {1'b0, 18'h11111, 1'b0},
    {1'b0, 18'h22222, 1'b0},
    {1'b1, 18'h15A3C, 1'b1},
    {1'b1, 18'h00001, 1'b1},
    {1'b1, 18'h20000, 1'b1}
  };

  logic          sendClk = 1'b0;
  logic          recvClk = 1'b0;
  logic          rstN = 1'b0;
  logic          bypassOn = 1'b0;
  logic          sendWrite = 1'b0;
  logic [DW-1:0] sendData = '0;
  logic          recvRead = 1'b0;
  logic          sendFullN;
  logic [DW-1:0] recvData;
  logic          recvAvail;
  logic          recvBypassN;

  int tests = 0;
  int fails = 0;
  logic curMode = 1'b0;

  always #(CLK_PERIOD/2)  sendClk = ~sendClk;
  always #(RECV_PERIOD/2) recvClk = ~recvClk;

  xclk_bypass_mailbox #(.DW(DW)) uut (
    .sendClk(sendClk), .recvClk(recvClk), .rstN(rstN),
    .bypassOn(bypassOn), .sendWrite(sendWrite), .sendData(sendData),
    .sendFullN(sendFullN), .recvRead(recvRead), .recvData(recvData),
    .recvAvail(recvAvail), .recvBypassN(recvBypassN)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendTick();
    @(posedge sendClk); @(negedge sendClk);
  endtask

  task automatic recvTick();
    @(posedge recvClk); @(negedge recvClk);
  endtask

  task automatic checkReset(input string tag);
    chk(sendFullN == 1'b1, {tag, " R1 sendFullN"}, 32'(sendFullN), 1);
    chk(recvAvail == 1'b0, {tag, " R1 recvAvail"}, 32'(recvAvail), 0);
    chk(recvBypassN == 1'b1, {tag, " R1 recvBypassN"}, 32'(recvBypassN), 1);
    chk(recvData == '0, {tag, " R1 recvData"}, 32'(recvData), 0);
  endtask

  task automatic setMode(input logic m);
    sendTick();
    bypassOn = m;
    curMode  = m;
    for (int i = 0; i < 5; i++) recvTick();
    // R2
    chk(recvBypassN == ~m, "R2 bypass flag", 32'(recvBypassN), 32'(~m));
    sendTick();
  endtask

  task automatic doWrite(input logic [DW-1:0] d);
    sendData  = d;
    sendWrite = 1'b1;
    sendTick();
    sendWrite = 1'b0;
  endtask

  task automatic waitAvail(input logic [DW-1:0] d);
    bit seen = 0;
    for (int i = 0; i < 6 && !seen; i++) begin
      recvTick();
      if (recvAvail) seen = 1;
    end
    chk(seen, "R4 recvAvail rise", 32'(recvAvail), 1);
    chk(recvData == d, "R4 recvData", 32'(recvData), 32'(d));
  endtask

  task automatic doRead(input logic [DW-1:0] d);
    recvRead = 1'b1;
    recvTick();
    recvRead = 1'b0;
    chk(recvAvail == 1'b0, "R5 recvAvail after read", 32'(recvAvail), 0);
    chk(recvData == d, "R10 recvData held", 32'(recvData), 32'(d));
  endtask

  task automatic waitFullRelease();
    bit back = 0;
    for (int i = 0; i < 6 && !back; i++) begin
      sendTick();
      if (sendFullN) back = 1;
    end
    chk(back, "R6 sendFullN release", 32'(sendFullN), 1);
  endtask

  task automatic runMsg(input logic [DW-1:0] d);
    doWrite(d);
    chk(sendFullN == 1'b0, "R3 sendFullN low", 32'(sendFullN), 0);
    recvTick();
    chk(recvAvail == 1'b0, "R4 not before third edge", 32'(recvAvail), 0);
    waitAvail(d);
    doRead(d);
    waitFullRelease();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] lastData;
    // R1 during and after reset
    repeat (3) sendTick();
    checkReset("in reset");
    rstN = 1'b1;
    repeat (3) recvTick();
    checkReset("after reset");
    lastData = '0;

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      logic          m;
      logic [DW-1:0] d;
      logic          acc;
      {m, d, acc} = VEC[v];
      if (m != curMode) setMode(m);
      if (acc) begin
        runMsg(d);
        lastData = d;
      end else begin
        // R8 write with bypass off
        doWrite(d);
        chk(sendFullN == 1'b1, "R8 sendFullN stays", 32'(sendFullN), 1);
        for (int i = 0; i < 6; i++) recvTick();
        chk(recvAvail == 1'b0, "R8 recvAvail stays", 32'(recvAvail), 0);
        chk(recvData == lastData, "R8 recvData unchanged", 32'(recvData), 32'(lastData));
      end
    end

    // R7 write while pending is ignored
    doWrite(18'h0ABCD);
    chk(sendFullN == 1'b0, "R7 first accepted", 32'(sendFullN), 0);
    sendTick();
    doWrite(18'h3C3C3);
    chk(sendFullN == 1'b0, "R7 still pending", 32'(sendFullN), 0);
    waitAvail(18'h0ABCD);
    doRead(18'h0ABCD);
    waitFullRelease();
    for (int i = 0; i < 6; i++) recvTick();
    chk(recvAvail == 1'b0, "R7 no second message", 32'(recvAvail), 0);
    chk(recvData == 18'h0ABCD, "R7 data not overwritten", 32'(recvData), 32'h0ABCD);

    // R9 read with nothing available
    recvRead = 1'b1;
    recvTick();
    recvRead = 1'b0;
    recvTick();
    chk(recvAvail == 1'b0, "R9 recvAvail stays", 32'(recvAvail), 0);
    chk(recvData == 18'h0ABCD, "R9 recvData unchanged", 32'(recvData), 32'h0ABCD);
    sendTick();
    runMsg(18'h12345);   // R9 handshake still intact, R6 new write accepted

    // R1 reset while a message is pending
    doWrite(18'h0F0F0);
    repeat (6) recvTick();
    rstN = 1'b0;
    recvTick();
    checkReset("mid-run reset");
    bypassOn = 1'b0;
    sendTick();
    rstN = 1'b1;
    repeat (3) recvTick();
    checkReset("after mid-run reset");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule